// File: doc/BRIEF.md
# Video Interrupt and Status Controller

This block raises the three interrupt requests of a tile-based video display controller and keeps the flags that the CPU reads back as a status word. A raster timing generator outside the block supplies a pulse at the start of every scanline, a frame pulse that accompanies the line pulse of line 0, and a horizontal blanking level. From these the block tracks the line number, decides when vertical blank begins, and counts scanlines for the horizontal interrupt. An asynchronous external interrupt pin is synchronised and edge-detected. When the freeze mode is on, an accepted external interrupt captures the live H/V position so that software can read it later.

Each interrupt channel is a two-state machine: IDLE moves to REQ when an enabled event arrives, and REQ returns to IDLE on an acknowledge pulse. A new event in the same cycle as the acknowledge keeps the channel in REQ. The vertical-interrupt status flag is a machine with two states, CLEAR and SET. Vertical blank entry moves it from CLEAR to SET. A status read moves it from SET to CLEAR, except in a cycle that also enters vertical blank. The H/V position latch has two states, LIVE and HELD. It moves from LIVE to HELD on an accepted external interrupt while freeze mode is on. It moves from HELD back to LIVE on the external acknowledge, or when freeze mode is turned off.

Top module: `vid_irq_status`

## Requirements
- R1: After reset all three interrupt requests are low, the odd-frame flag is 0 and the block reports vertical blank (status 0x3609 with empty FIFO, PAL strap high and hblank low).
- R2: With `cfg_line_reload` = N, the scanline down-counter counts the line pulses of the active area. At a line pulse it reloads N when it is 0 and signals an underflow. Otherwise it decrements. So one horizontal event occurs every N+1 active lines: 56 in a 224-line frame with N=3, 60 in a 240-line frame.
- R3: A line pulse that arrives while the block is in vertical blank reloads the counter and never produces a horizontal event.
- R4: A horizontal event raises `irq_h` only while `cfg_hint_en` is 1.
- R5: The line pulse that takes the line number to the last active line count enters vertical blank. That entry raises `irq_v` when `cfg_vint_en` is 1.
- R6: Status bit 7 is set on every vertical blank entry, whatever the enables. A status read clears it. If the read and the entry fall in the same cycle, the flag stays set.
- R7: A rising edge on `ext_pin` raises `irq_x` only while `cfg_xint_en` is 1. A pin held high does not raise it again.
- R8: An acknowledge pulse drops the matching request. An event for the same channel in the same cycle keeps the request high.
- R9: While `cfg_hv_freeze` is 1, an accepted external interrupt holds `hv_pos_out` at the value `hv_pos_in` had at that moment. The external acknowledge or clearing `cfg_hv_freeze` makes the output follow `hv_pos_in` again. With freeze off it always follows.
- R10: Status layout: bits 15..10 read 001101, bit 9 is FIFO empty, bit 8 is FIFO full, bit 7 is the vertical flag, bit 4 is the odd frame, bit 3 is vertical blank, bit 2 is horizontal blank and bit 0 is the PAL strap. Bits 6, 5 and 1 read 0.
- R11: At each frame pulse the odd-frame flag toggles when `cfg_interlace` is 1 and is cleared when it is 0.
- R12: The active area is 240 lines when `cfg_tall` is 1 and 224 lines when it is 0. Vertical blank is the state in which the line number is at or past that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle pulse at each scanline start |
| frame_start | input | 1 | One-cycle pulse together with the line 0 pulse |
| hblank_in | input | 1 | Horizontal blanking level from the raster generator |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| hv_pos_in | input | 16 | Live H/V position |
| fifo_empty_in | input | 1 | Write FIFO empty, passed to status |
| fifo_full_in | input | 1 | Write FIFO full, passed to status |
| region_pal | input | 1 | Region strap, 1 = PAL |
| cfg_hint_en | input | 1 | Horizontal interrupt enable |
| cfg_vint_en | input | 1 | Vertical interrupt enable |
| cfg_xint_en | input | 1 | External interrupt enable |
| cfg_hv_freeze | input | 1 | Freeze H/V position on external interrupt |
| cfg_tall | input | 1 | 1 = 240 active lines, 0 = 224 |
| cfg_interlace | input | 1 | Interlace on, toggles odd-frame flag |
| cfg_line_reload | input | 8 | Scanline counter reload value |
| status_rd | input | 1 | Status read strobe, clears vertical flag |
| ack_h | input | 1 | Horizontal interrupt acknowledge |
| ack_v | input | 1 | Vertical interrupt acknowledge |
| ack_x | input | 1 | External interrupt acknowledge |
| irq_h | output | 1 | Horizontal interrupt request |
| irq_v | output | 1 | Vertical interrupt request |
| irq_x | output | 1 | External interrupt request |
| hv_pos_out | output | 16 | Live or held H/V position |
| status_word | output | 16 | Packed status word |

## Verification
Two pairs of functions can coincide. The horizontal underflow pulse can arrive in the cycle when the CPU acknowledges an earlier horizontal request. A status read can arrive in the cycle when vertical blank is entered. The bench provokes the first by holding `ack_h` high in the cycle that follows a line pulse, with the counter reload set to 0. It provokes the second by asserting `status_rd` in the cycle after the line pulse that ends the active area. In both cases the new event must win: `irq_h` stays high, and status bit 7 still reads 1 until a later, separate read clears it.

// File: rtl/vis_pkg.sv
package vis_pkg;
    typedef enum logic {CH_IDLE, CH_REQ}   ch_state_t;
    typedef enum logic {HV_LIVE, HV_HELD}  hv_state_t;
    typedef enum logic {VF_CLEAR, VF_SET}  vf_state_t;
    localparam int unsigned N_CH = 3;
    localparam int unsigned CH_H = 0;
    localparam int unsigned CH_V = 1;
    localparam int unsigned CH_X = 2;
    localparam logic [5:0] ST_HI_FIXED = 6'b001101;
endpackage

// File: rtl/vis_line_track.sv
module vis_line_track #(
    parameter int unsigned LINE_W      = 9,
    parameter int unsigned SHORT_LINES = 224,
    parameter int unsigned TALL_LINES  = 240
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_start,
    input  logic frame_start,
    input  logic tall,
    input  logic interlace,
    output logic vblank,
    output logic vb_enter,
    output logic odd
);
    localparam logic [LINE_W-1:0] ACT_SHORT = LINE_W'(SHORT_LINES);
    localparam logic [LINE_W-1:0] ACT_TALL  = LINE_W'(TALL_LINES);
    localparam logic [LINE_W-1:0] IDX_MAX   = '1;

    logic [LINE_W-1:0] idx_q;
    logic [LINE_W-1:0] idx_nxt;
    logic [LINE_W-1:0] active;

    assign active  = tall ? ACT_TALL : ACT_SHORT;
    assign idx_nxt = (idx_q == IDX_MAX) ? idx_q : idx_q + 1'b1;
    assign vblank  = (idx_q >= active);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= IDX_MAX;
            vb_enter <= 1'b0;
            odd      <= 1'b0;
        end else begin
            vb_enter <= 1'b0;
            if (frame_start) begin
                idx_q <= '0;
                odd   <= interlace ? ~odd : 1'b0;
            end else if (line_start) begin
                idx_q    <= idx_nxt;
                vb_enter <= (idx_nxt == active);
            end
        end
    end

    // R12: entry pulse only ever marks a line inside vertical blank
    a_r12_enter_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
        vb_enter |-> vblank);
    // R5: entry is a single-cycle pulse
    a_r5_enter_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        vb_enter |=> !vb_enter);
    // R11: parity only moves on a frame pulse
    a_r11_odd_still: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(odd));
endmodule

// File: rtl/vis_hline_cnt.sv
module vis_hline_cnt #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic             vblank,
    input  logic [CNT_W-1:0] reload,
    output logic             uflow
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            uflow <= 1'b0;
        end else begin
            uflow <= 1'b0;
            if (line_start) begin
                if (vblank) begin
                    cnt_q <= reload;
                end else if (cnt_q == '0) begin
                    cnt_q <= reload;
                    uflow <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    // R3: no horizontal event from a line spent in vertical blank
    a_r3_quiet_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && vblank) |=> !uflow);
    // R2: an underflow always follows a line pulse
    a_r2_uf_after_line: assert property (@(posedge clk) disable iff (!rst_n)
        uflow |-> $past(line_start));
endmodule

// File: rtl/vis_irq_chan.sv
module vis_irq_chan
    import vis_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ev,
    input  logic ack,
    output logic req
);
    ch_state_t st_q;
    ch_state_t st_nxt;
    logic      take;

    assign take = en && ev;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CH_IDLE;
        else        st_q <= st_nxt;
    end

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            CH_IDLE: if (take)        st_nxt = CH_REQ;
            CH_REQ:  if (ack && !take) st_nxt = CH_IDLE;
            default: st_nxt = CH_IDLE;
        endcase
    end

    always_comb begin
        req = (st_q == CH_REQ);
    end

    // R8: an acknowledge with no new event drops the request
    a_r8_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack && !(en && ev)) |=> !req);
    // R8: a new event beats a coincident acknowledge
    a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ev) |=> req);
    // R4: a request only rises from an enabled event
    a_r4_gated_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(en && ev));
endmodule

// File: rtl/vis_hv_latch.sv
module vis_hv_latch
    import vis_pkg::*;
#(
    parameter int unsigned HV_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            freeze_en,
    input  logic            trig,
    input  logic            release_i,
    input  logic [HV_W-1:0] hv_in,
    output logic [HV_W-1:0] hv_out
);
    hv_state_t       st_q;
    hv_state_t       st_nxt;
    logic [HV_W-1:0] held_q;
    logic            capture;

    always_comb begin
        st_nxt  = st_q;
        capture = 1'b0;
        unique case (st_q)
            HV_LIVE: begin
                if (freeze_en && trig) begin
                    st_nxt  = HV_HELD;
                    capture = 1'b1;
                end
            end
            HV_HELD: begin
                if (!freeze_en) begin
                    st_nxt = HV_LIVE;
                end else if (trig) begin
                    capture = 1'b1;
                end else if (release_i) begin
                    st_nxt = HV_LIVE;
                end
            end
            default: st_nxt = HV_LIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= HV_LIVE;
            held_q <= '0;
        end else begin
            st_q <= st_nxt;
            if (capture) held_q <= hv_in;
        end
    end

    always_comb begin
        hv_out = (st_q == HV_HELD) ? held_q : hv_in;
    end

    // R9: freeze off always returns to tracking
    a_r9_off_goes_live: assert property (@(posedge clk) disable iff (!rst_n)
        !freeze_en |=> (st_q == HV_LIVE));
    // R9: a held position does not move without a new trigger
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == HV_HELD) && $past(st_q == HV_HELD) && !$past(trig)) |-> $stable(hv_out));
endmodule

// File: rtl/vid_irq_status.sv
module vid_irq_status
    import vis_pkg::*;
#(
    parameter int unsigned LINE_W      = 9,
    parameter int unsigned SHORT_LINES = 224,
    parameter int unsigned TALL_LINES  = 240,
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned HV_W        = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic             frame_start,
    input  logic             hblank_in,
    input  logic             ext_pin,
    input  logic [HV_W-1:0]  hv_pos_in,
    input  logic             fifo_empty_in,
    input  logic             fifo_full_in,
    input  logic             region_pal,
    input  logic             cfg_hint_en,
    input  logic             cfg_vint_en,
    input  logic             cfg_xint_en,
    input  logic             cfg_hv_freeze,
    input  logic             cfg_tall,
    input  logic             cfg_interlace,
    input  logic [CNT_W-1:0] cfg_line_reload,
    input  logic             status_rd,
    input  logic             ack_h,
    input  logic             ack_v,
    input  logic             ack_x,
    output logic             irq_h,
    output logic             irq_v,
    output logic             irq_x,
    output logic [HV_W-1:0]  hv_pos_out,
    output logic [15:0]      status_word
);
    logic vblank, vb_enter, odd, h_uflow, x_edge;
    logic [SYNC_STAGES:0] sync_q;
    logic [N_CH-1:0] ch_en, ch_ev, ch_ack, ch_req;
    vf_state_t vf_q, vf_nxt;

    vis_line_track #(
        .LINE_W(LINE_W), .SHORT_LINES(SHORT_LINES), .TALL_LINES(TALL_LINES)
    ) u_track (
        .clk(clk), .rst_n(rst_n), .line_start(line_start),
        .frame_start(frame_start), .tall(cfg_tall), .interlace(cfg_interlace),
        .vblank(vblank), .vb_enter(vb_enter), .odd(odd)
    );

    vis_hline_cnt #(.CNT_W(CNT_W)) u_hcnt (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .vblank(vblank),
        .reload(cfg_line_reload), .uflow(h_uflow)
    );

    // external pin synchroniser and rising-edge detect
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-1:0], ext_pin};
    end
    assign x_edge = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

    assign ch_en  = {cfg_xint_en, cfg_vint_en, cfg_hint_en};
    assign ch_ev  = {x_edge, vb_enter, h_uflow};
    assign ch_ack = {ack_x, ack_v, ack_h};

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        vis_irq_chan u_chan (
            .clk(clk), .rst_n(rst_n), .en(ch_en[i]), .ev(ch_ev[i]),
            .ack(ch_ack[i]), .req(ch_req[i])
        );
    end

    assign irq_h = ch_req[CH_H];
    assign irq_v = ch_req[CH_V];
    assign irq_x = ch_req[CH_X];

    vis_hv_latch #(.HV_W(HV_W)) u_hv (
        .clk(clk), .rst_n(rst_n), .freeze_en(cfg_hv_freeze),
        .trig(cfg_xint_en && x_edge), .release_i(ack_x),
        .hv_in(hv_pos_in), .hv_out(hv_pos_out)
    );

    // vertical-interrupt status flag
    always_ff @(posedge clk) begin
        if (!rst_n) vf_q <= VF_CLEAR;
        else        vf_q <= vf_nxt;
    end

    always_comb begin
        vf_nxt = vf_q;
        unique case (vf_q)
            VF_CLEAR: if (vb_enter)                 vf_nxt = VF_SET;
            VF_SET:   if (status_rd && !vb_enter)   vf_nxt = VF_CLEAR;
            default:  vf_nxt = VF_CLEAR;
        endcase
    end

    always_comb begin
        status_word = {ST_HI_FIXED, fifo_empty_in, fifo_full_in,
                       (vf_q == VF_SET), 2'b00, odd, vblank, hblank_in,
                       1'b0, region_pal};
    end

    // R6: entry always sets the flag, even against a read
    a_r6_entry_sets: assert property (@(posedge clk) disable iff (!rst_n)
        vb_enter |=> status_word[7]);
    // R6: a read with no entry clears it
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !vb_enter) |=> !status_word[7]);
    // R7: a held pin gives a single edge
    a_r7_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        x_edge |=> !x_edge);
endmodule

// File: tb/vid_irq_status_tb_top.sv
module vid_irq_status_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic line_start = 0, frame_start = 0, hblank_in = 0, ext_pin = 0;
    logic [15:0] hv_pos_in = 16'h00AA;
    logic fifo_empty_in = 1, fifo_full_in = 0, region_pal = 1;
    logic cfg_hint_en = 0, cfg_vint_en = 0, cfg_xint_en = 0, cfg_hv_freeze = 0;
    logic cfg_tall = 0, cfg_interlace = 0;
    logic [7:0] cfg_line_reload = 8'd3;
    logic status_rd = 0, ack_h = 0, ack_v = 0, ack_x = 0;
    logic irq_h, irq_v, irq_x;
    logic [15:0] hv_pos_out, status_word;

    vid_irq_status dut_i (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .frame_start(frame_start),
        .hblank_in(hblank_in), .ext_pin(ext_pin), .hv_pos_in(hv_pos_in),
        .fifo_empty_in(fifo_empty_in), .fifo_full_in(fifo_full_in),
        .region_pal(region_pal), .cfg_hint_en(cfg_hint_en), .cfg_vint_en(cfg_vint_en),
        .cfg_xint_en(cfg_xint_en), .cfg_hv_freeze(cfg_hv_freeze), .cfg_tall(cfg_tall),
        .cfg_interlace(cfg_interlace), .cfg_line_reload(cfg_line_reload),
        .status_rd(status_rd), .ack_h(ack_h), .ack_v(ack_v), .ack_x(ack_x),
        .irq_h(irq_h), .irq_v(irq_v), .irq_x(irq_x),
        .hv_pos_out(hv_pos_out), .status_word(status_word)
    );

    typedef struct {
        int          kind;   // 0 snapshot, 1 compare h count, 2 clear h count
        string       tag;
        logic [2:0]  irq;    // {x, v, h}
        logic [15:0] st;
        logic [15:0] hv;
        bit          chk_hv;
        int          cnt;
    } exp_t;

    exp_t sb_q[$];
    int pushed_n = 0, popped_n = 0;
    int n_checks = 0, n_errors = 0;
    int hcnt = 0;
    logic prev_h = 0;
    bit auto_ack_h = 0;

    // monitor: count horizontal rises and judge queued expectations
    always @(negedge clk) begin
        if (irq_h && !prev_h) hcnt = hcnt + 1;
        prev_h = irq_h;
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            if (e.kind == 2) begin
                hcnt = 0;
            end else if (e.kind == 1) begin
                n_checks++;
                if (hcnt != e.cnt) begin
                    n_errors++;
                    $display("FAIL %s: h interrupts %0d expected %0d", e.tag, hcnt, e.cnt);
                end
            end else begin
                n_checks++;
                if ({irq_x, irq_v, irq_h} !== e.irq || status_word !== e.st ||
                    (e.chk_hv && hv_pos_out !== e.hv)) begin
                    n_errors++;
                    $display("FAIL %s: irq=%b st=%h hv=%h expected irq=%b st=%h hv=%h",
                             e.tag, {irq_x, irq_v, irq_h}, status_word, hv_pos_out,
                             e.irq, e.st, e.hv);
                end
            end
            popped_n++;
        end
    end

    task automatic settle();
        wait (popped_n == pushed_n);
        @(negedge clk);
    endtask

    task automatic exp_snap(string tag, logic [2:0] irq, logic [15:0] st,
                            logic [15:0] hv, bit chk_hv);
        exp_t e;
        e.kind = 0; e.tag = tag; e.irq = irq; e.st = st; e.hv = hv;
        e.chk_hv = chk_hv; e.cnt = 0;
        sb_q.push_back(e); pushed_n++;
        settle();
    endtask

    task automatic exp_hcnt(string tag, int cnt);
        exp_t e;
        e.kind = 1; e.tag = tag; e.irq = '0; e.st = '0; e.hv = '0;
        e.chk_hv = 0; e.cnt = cnt;
        sb_q.push_back(e); pushed_n++;
        settle();
    endtask

    task automatic clr_hcnt();
        exp_t e;
        e.kind = 2; e.tag = ""; e.irq = '0; e.st = '0; e.hv = '0;
        e.chk_hv = 0; e.cnt = 0;
        sb_q.push_back(e); pushed_n++;
        settle();
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ack(int which);
        if (which == 0) ack_h = 1; else if (which == 1) ack_v = 1; else ack_x = 1;
        @(negedge clk);
        ack_h = 0; ack_v = 0; ack_x = 0;
        idle(2);
    endtask

    task automatic read_status();
        status_rd = 1; @(negedge clk); status_rd = 0; idle(2);
    endtask

    task automatic one_line(bit first);
        line_start = 1; frame_start = first;
        @(negedge clk);
        line_start = 0; frame_start = 0;
        idle(3);
        if (auto_ack_h && irq_h) pulse_ack(0);
    endtask

    task automatic lines(int n);
        for (int i = 0; i < n; i++) one_line(0);
    endtask

    task automatic frame(int total);
        one_line(1);
        lines(total - 1);
    endtask

    initial begin
        idle(5);
        rst_n = 1;
        idle(2);
        // R1 R10: reset state and fixed status pattern
        exp_snap("R1 reset", 3'b000, 16'h3609, 16'h00AA, 1);

        // R2 R3 R5: short frame, reload 3
        cfg_hint_en = 1; cfg_vint_en = 1; auto_ack_h = 1;
        clr_hcnt();
        frame(262);
        exp_hcnt("R2 R3 short frame count", 56);
        exp_snap("R5 vertical request at blank", 3'b010, 16'h3689, 16'h0, 0);
        pulse_ack(1);
        read_status();
        exp_snap("R8 R6 ack and read clear", 3'b000, 16'h3609, 16'h0, 0);

        // R12 R5: tall frame
        cfg_tall = 1;
        clr_hcnt();
        one_line(1);
        lines(239);
        exp_snap("R12 still active at line 239", 3'b000, 16'h3601, 16'h0, 0);
        lines(1);
        exp_snap("R5 R12 blank at line 240", 3'b010, 16'h3689, 16'h0, 0);
        lines(22);
        exp_hcnt("R2 tall frame count", 60);
        pulse_ack(1);
        read_status();

        // R4 R6: enables off, flag still set
        cfg_tall = 0; cfg_hint_en = 0; cfg_vint_en = 0; cfg_line_reload = 8'd0;
        clr_hcnt();
        frame(262);
        exp_hcnt("R4 gated horizontal", 0);
        exp_snap("R6 flag set without enable", 3'b000, 16'h3689, 16'h0, 0);
        read_status();
        exp_snap("R6 read clears flag", 3'b000, 16'h3609, 16'h0, 0);

        // R8: acknowledge collides with a new horizontal event
        cfg_hint_en = 1; auto_ack_h = 0;
        one_line(1);
        lines(1);
        exp_snap("R2 reload 0 underflow", 3'b001, 16'h3601, 16'h0, 0);
        line_start = 1; @(negedge clk);
        line_start = 0; ack_h = 1; @(negedge clk);
        ack_h = 0; idle(2);
        exp_snap("R8 event beats ack", 3'b001, 16'h3601, 16'h0, 0);
        pulse_ack(0);
        exp_snap("R8 ack drops", 3'b000, 16'h3601, 16'h0, 0);

        // R6: status read collides with blank entry
        auto_ack_h = 1;
        lines(221);
        line_start = 1; @(negedge clk);
        line_start = 0; status_rd = 1; @(negedge clk);
        status_rd = 0; idle(3);
        pulse_ack(0);
        exp_snap("R6 entry beats read", 3'b000, 16'h3689, 16'h0, 0);
        read_status();
        exp_snap("R6 later read clears", 3'b000, 16'h3609, 16'h0, 0);

        // R11: odd frame flag
        cfg_hint_en = 0; cfg_interlace = 1;
        one_line(1);
        exp_snap("R11 odd after first frame", 3'b000, 16'h3611, 16'h0, 0);
        one_line(1);
        exp_snap("R11 even after second frame", 3'b000, 16'h3601, 16'h0, 0);
        one_line(1);
        cfg_interlace = 0;
        one_line(1);
        exp_snap("R11 cleared without interlace", 3'b000, 16'h3601, 16'h0, 0);

        // R7 R9: external interrupt with freeze
        cfg_xint_en = 1; cfg_hv_freeze = 1; hv_pos_in = 16'h1234;
        ext_pin = 1; idle(6);
        hv_pos_in = 16'h5678; idle(2);
        exp_snap("R9 position held", 3'b100, 16'h3601, 16'h1234, 1);
        pulse_ack(2);
        idle(6);
        exp_snap("R7 R9 released, no retrigger", 3'b000, 16'h3601, 16'h5678, 1);
        ext_pin = 0; idle(4);
        cfg_hv_freeze = 0;
        ext_pin = 1; idle(6);
        hv_pos_in = 16'h0BCD; idle(2);
        exp_snap("R9 freeze off tracks", 3'b100, 16'h3601, 16'h0BCD, 1);
        pulse_ack(2);
        ext_pin = 0; idle(4);
        cfg_xint_en = 0; cfg_hv_freeze = 1;
        ext_pin = 1; idle(6);
        hv_pos_in = 16'h2222; idle(2);
        exp_snap("R7 gated external", 3'b000, 16'h3601, 16'h2222, 1);
        ext_pin = 0; idle(4);
        cfg_xint_en = 1; hv_pos_in = 16'h3333;
        ext_pin = 1; idle(6);
        hv_pos_in = 16'h4444; idle(2);
        exp_snap("R9 held again", 3'b100, 16'h3601, 16'h3333, 1);
        cfg_hv_freeze = 0; idle(2);
        exp_snap("R9 freeze cleared releases", 3'b100, 16'h3601, 16'h4444, 1);
        pulse_ack(2);
        ext_pin = 0; idle(4);

        // R10: pass-through fields
        hblank_in = 1; fifo_full_in = 1; fifo_empty_in = 0; region_pal = 0;
        idle(1);
        exp_snap("R10 layout", 3'b000, 16'h3504, 16'h0, 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule